// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from the transmit engine, the receive engine, the bus master and a general-purpose timer, and holds each one as a sticky bit in a 32-bit status word. Two summary bits are formed from these sticky bits. The normal summary covers the completion-type events. The abnormal summary covers the error and stall events. A single active-low interrupt request is driven under a two-level mask. Each source has its own enable, and a group enable gates all normal sources or all abnormal sources at once.

The host reaches both words through a plain register port. It gives a write strobe, a word select and write data, and it reads the selected word back combinationally. Status bits clear when the host writes a one to them. On the rising edge of the fatal bus error bit, the block stores a 3-bit fatal error code. Two 3-bit process-state fields from the engines pass straight into the status word.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the status word reads 0xFC005410, the mask word reads 0xFFFE5410, and irq_n is 1. In the status word, bits 4, 10, 12, 14 and 31:26 always read 1. In the mask word, bits 4, 10, 12, 14 and 31:17 always read 1.
- R2: A pulse on evt_pulse bit k sets a status bit, and the bit reads 1 from the next cycle until the host clears it. The mapping from evt_pulse bit to status bit is: 0→0 (transmit done), 1→1 (transmit stopped), 2→2 (transmit buffer unavailable), 3→3 (jabber timeout), 4→5 (underflow), 5→6 (receive done), 6→7 (receive buffer unavailable), 7→8 (receive stopped), 8→9 (receive watchdog), 9→11 (timer expired), 10→13 (fatal bus error).
- R3: A write to the status word (reg_sel=0) clears each event bit whose data bit is 1. Event bits whose data bit is 0 are unchanged. The write has no effect on any other status bit.
- R4: If an event pulse and a host clear hit the same status bit in the same cycle, the bit stays 1.
- R5: Status bit 16 reads 1 whenever any of status bits 0, 2 or 6 is 1. Status bit 15 reads 1 whenever any of status bits 1, 3, 5, 7, 8, 9, 11 or 13 is 1.
- R6: A write to the mask word (reg_sel=1) stores data bits 0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13, 15 and 16. All other mask bits keep their fixed values.
- R7: irq_n is 0 exactly while some status event bit is 1 and both of its enables are 1. The enables are its own mask bit at the same position, and mask bit 16 for bits 0, 2 and 6 or mask bit 15 for the other event bits. irq_n returns to 1 in the cycle in which the last such bit is cleared.
- R8: Status bits 25:23 show fatal_code, which is stored when status bit 13 goes from 0 to 1. A fatal event while bit 13 is already 1 leaves the code unchanged. The code values are 000 for a parity error, 001 for a master abort and 010 for a target abort. The code is 000 after reset.
- R9: Status bits 22:20 follow tx_state and status bits 19:17 follow rx_state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 11 | Event pulses, one per source (mapping in R2) |
| fatal_code | input | 3 | Error code presented with a fatal event |
| tx_state | input | 3 | Transmit process state, passed through |
| rx_state | input | 3 | Receive process state, passed through |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the mask word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected word, read combinationally |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that event pulses and host writes arrive as ordinary synchronous inputs that may coincide in any combination. They also assume that fatal_code is valid in every cycle that carries a fatal pulse. The stimulus drives each event alone and then together with a clear of the same bit. It visits all four combinations of source enable and group enable for every source. It sends fatal pulses both while bit 13 is clear and while it is already set, so that only first-edge captures change the code.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_SRC  = 11;
  localparam int CODE_W   = 3;
  localparam int STATE_W  = 3;

  localparam int NIS_POS  = 16;
  localparam int AIS_POS  = 15;
  localparam int CODE_LSB = 23;
  localparam int TXS_LSB  = 20;
  localparam int RXS_LSB  = 17;
  localparam int FATAL_SRC = 10;

  localparam logic [WORD_W-1:0] STAT_FIXED_ONES = 32'hFC00_5410;
  localparam logic [WORD_W-1:0] MASK_FIXED_ONES = 32'hFFFE_5410;
  localparam logic [WORD_W-1:0] NORM_GROUP      = 32'h0000_0045;
  localparam logic [WORD_W-1:0] ABN_GROUP       = 32'h0000_2BAA;
  localparam logic [WORD_W-1:0] MASK_WRITABLE   = NORM_GROUP | ABN_GROUP |
                                                  (32'h1 << NIS_POS) | (32'h1 << AIS_POS);

  function automatic int src_pos(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 5;
      5: return 6;
      6: return 7;
      7: return 8;
      8: return 9;
      9: return 11;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] bits_q
);
  logic [N-1:0] bits_d;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_comb begin
      bits_d[k] = (bits_q[k] & ~clr_i[k]) | set_i[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q[k] <= 1'b0;
      else        bits_q[k] <= bits_d[k];
    end

    // R2: a set bit survives until cleared
    a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bits_q[k] && !clr_i[k]) |=> bits_q[k]);
    // R4: an event wins over a coincident clear
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> bits_q[k]);
    // R3: a clear without an event empties the bit
    a_r3_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !bits_q[k]);
  end
endmodule

// File: rtl/irq_fatal_latch.sv
module irq_fatal_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fatal_evt,
  input  logic         fatal_bit,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code_q
);
  logic         capture;
  logic [W-1:0] code_d;

  always_comb begin
    capture = fatal_evt & ~fatal_bit;
    code_d  = capture ? code_in : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  // R8: the code only moves in the cycle the fatal bit rises
  a_r8_code_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(fatal_bit) |-> $stable(code_q));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = wr_en ? (wdata & WMASK) : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // R6: bits outside the writable set never hold a one
  a_r6_fixed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~WMASK) == '0);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   evt_pulse,
  input  logic [CODE_W-1:0]    fatal_code,
  input  logic [STATE_W-1:0]   tx_state,
  input  logic [STATE_W-1:0]   rx_state,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 irq_n
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] src_clr;
  logic [WORD_W-1:0]  ev_word;
  logic [WORD_W-1:0]  mask_q;
  logic [WORD_W-1:0]  group_en;
  logic [WORD_W-1:0]  stat_word;
  logic [CODE_W-1:0]  code_q;
  logic               stat_wr;
  logic               mask_wr;
  logic               nis;
  logic               ais;
  logic               irq_req;

  always_comb begin
    stat_wr = reg_wr & ~reg_sel;
    mask_wr = reg_wr &  reg_sel;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_map
    localparam int P = src_pos(k);
    always_comb begin
      src_clr[k] = stat_wr & reg_wdata[P];
    end
  end

  always_comb begin
    ev_word = '0;
    for (int k = 0; k < NUM_SRC; k++) ev_word[src_pos(k)] = src_q[k];
  end

  irq_sticky_bank #(.N(NUM_SRC)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_pulse),
    .clr_i  (src_clr),
    .bits_q (src_q)
  );

  irq_fatal_latch #(.W(CODE_W)) u_fatal (
    .clk       (clk),
    .rst_n     (rst_n),
    .fatal_evt (evt_pulse[FATAL_SRC]),
    .fatal_bit (src_q[FATAL_SRC]),
    .code_in   (fatal_code),
    .code_q    (code_q)
  );

  irq_mask_reg #(.W(WORD_W), .WMASK(MASK_WRITABLE)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .wdata  (reg_wdata),
    .mask_q (mask_q)
  );

  always_comb begin
    nis      = |(ev_word & NORM_GROUP);
    ais      = |(ev_word & ABN_GROUP);
    group_en = ({WORD_W{mask_q[NIS_POS]}} & NORM_GROUP) |
               ({WORD_W{mask_q[AIS_POS]}} & ABN_GROUP);
    irq_req  = |(ev_word & mask_q & group_en);
    irq_n    = ~irq_req;

    stat_word = STAT_FIXED_ONES | ev_word;
    stat_word[NIS_POS] = nis;
    stat_word[AIS_POS] = ais;
    stat_word[CODE_LSB +: CODE_W] = code_q;
    stat_word[TXS_LSB +: STATE_W] = tx_state;
    stat_word[RXS_LSB +: STATE_W] = rx_state;

    reg_rdata = reg_sel ? (mask_q | MASK_FIXED_ONES) : stat_word;
  end

  // R7: a request always has a live, group-enabled summary behind it
  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((nis && mask_q[NIS_POS]) || (ais && mask_q[AIS_POS])));
  // R5: summaries only appear once some event has been seen
  a_r5_summary_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nis || ais) |-> $past(|evt_pulse));
endmodule

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt_pulse = '0;
  logic [2:0]  fatal_code = '0;
  logic [2:0]  tx_state = '0;
  logic [2:0]  rx_state = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_ev   = '0;
  logic [31:0] m_mask = '0;
  logic [2:0]  m_code = '0;

  localparam logic [31:0] NORM = 32'h0000_0045;
  localparam logic [31:0] ABN  = 32'h0000_2BAA;

  always #5 clk = ~clk;

  irq_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .fatal_code(fatal_code),
    .tx_state(tx_state), .rx_state(rx_state), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  function automatic int pos_of(input int k);
    int t [11] = '{0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13};
    return t[k];
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = 32'hFC00_5410 | m_ev;
    s[16] = |(m_ev & NORM);
    s[15] = |(m_ev & ABN);
    s[25:23] = m_code;
    s[22:20] = tx_state;
    s[19:17] = rx_state;
    return s;
  endfunction

  function automatic logic exp_irq_n();
    logic [31:0] g;
    g = (m_mask[16] ? NORM : 32'h0) | (m_mask[15] ? ABN : 32'h0);
    return ~|(m_ev & m_mask & g);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    reg_sel = 1'b0; #1;
    check(req, reg_rdata, exp_status());
    reg_sel = 1'b1; #1;
    check(req, reg_rdata, m_mask | 32'hFFFE_5410);
    check(req, {31'b0, irq_n}, {31'b0, exp_irq_n()});
    reg_sel = 1'b0;
  endtask

  // one clock: drive, update model, advance to the next falling edge
  task automatic cyc(input logic [10:0] ev, input logic [2:0] code,
                     input logic we, input logic sel, input logic [31:0] d);
    logic [31:0] evw, clr;
    evt_pulse = ev; fatal_code = code; reg_wr = we; reg_sel = sel; reg_wdata = d;
    evw = '0;
    for (int k = 0; k < 11; k++) if (ev[k]) evw[pos_of(k)] = 1'b1;
    clr = (we && !sel) ? (d & (NORM | ABN)) : 32'h0;
    if (ev[10] && !m_ev[13]) m_code = code;
    m_ev = (m_ev & ~clr) | evw;
    if (we && sel) m_mask = d & (NORM | ABN | 32'h0001_8000);
    @(posedge clk); @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin : watchdog
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R2, R5: each source alone, masks off
    for (int k = 0; k < 11; k++) begin
      cyc(11'h0, 3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);
      cyc(11'h1 << k, 3'(k % 3), 1'b0, 1'b0, 32'h0);
      check_all("R2 R5 single source");
      cyc(11'h0, 3'd0, 1'b0, 1'b0, 32'h0);
      check_all("R2 sticky hold");
    end

    // R7: every source against all enable combinations, then release
    for (int k = 0; k < 11; k++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] mw;
        logic grp;
        grp = NORM[pos_of(k)] ? 1'b1 : 1'b0;
        mw = (c[0] ? (32'h1 << pos_of(k)) : 32'h0) |
             (c[1] ? (grp ? 32'h0001_0000 : 32'h0000_8000) : 32'h0);
        cyc(11'h0, 3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        cyc(11'h0, 3'd0, 1'b1, 1'b1, mw);
        check_all("R6 R7 mask write");
        cyc(11'h1 << k, 3'd1, 1'b0, 1'b0, 32'h0);
        check_all("R7 irq with enables");
        cyc(11'h0, 3'd0, 1'b1, 1'b0, 32'h1 << pos_of(k));
        check_all("R7 release on clear");
      end
    end

    // R3: zeros and fixed bits in the write data change nothing
    cyc(11'h7FF, 3'd2, 1'b1, 1'b0, 32'hFFFF_FFFF);
    check_all("R3 all set");
    cyc(11'h0, 3'd0, 1'b1, 1'b0, 32'h0);
    check_all("R3 write zero");
    cyc(11'h0, 3'd0, 1'b1, 1'b0, ~(NORM | ABN));
    check_all("R3 write non-event bits");
    cyc(11'h0, 3'd0, 1'b1, 1'b0, 32'h0000_0041);
    check_all("R3 partial clear");

    // R4: event and clear together
    for (int k = 0; k < 11; k++) begin
      cyc(11'h1 << k, 3'd3, 1'b1, 1'b0, 32'h1 << pos_of(k));
      check_all("R4 event beats clear");
    end

    // R6: mask write of all ones, then zero
    cyc(11'h0, 3'd0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    check_all("R6 mask all ones");
    cyc(11'h0, 3'd0, 1'b1, 1'b1, 32'h0);
    check_all("R6 mask zero");

    // R8: capture on first edge only
    cyc(11'h0, 3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    cyc(11'h400, 3'd1, 1'b0, 1'b0, 32'h0);
    check_all("R8 capture master abort");
    cyc(11'h400, 3'd2, 1'b0, 1'b0, 32'h0);
    check_all("R8 second fatal ignored");
    cyc(11'h0, 3'd0, 1'b1, 1'b0, 32'h0000_2000);
    check_all("R8 code holds after clear");
    cyc(11'h400, 3'd2, 1'b0, 1'b0, 32'h0);
    check_all("R8 capture target abort");
    cyc(11'h400, 3'd0, 1'b1, 1'b0, 32'h0000_2000);
    check_all("R8 clear plus fatal keeps code");

    // R9: state pass-through sweep
    for (int t = 0; t < 8; t++) begin
      for (int r = 0; r < 8; r++) begin
        tx_state = 3'(t); rx_state = 3'(r);
        check_all("R9 state fields");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule